// File: doc/BRIEF.md
# Clear, Load, Down-One, Up-Three Counter

This block is a small register-based counter whose next value is picked by three control inputs sampled on the rising clock edge. An active-low clear forces the count to zero. Otherwise an active-high load copies a parallel data word into the register. When neither clear nor load is active, a direction input makes the count step down by one or up by three.

The count changes on every clock edge. There is no hold condition, and every control acts only on the clock edge. Arithmetic wraps around the register width. The block suits sequencing jobs where a fixed forward stride and a unit backward stride are both needed, and where software or a neighbouring block seeds the starting value through the load path.

The clear input also serves as the way to bring the count to a known value after power-up. The block has no separate reset.

Top module: `clr_ld_counter`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever `load`, `din` and `step_up` are.
- R2: When `clear_n` is 1 and `load` is 1 at a rising edge, `count` becomes `din` after that edge, whatever `step_up` is.
- R3: When `clear_n` is 1, `load` is 0 and `step_up` is 0 at a rising edge, `count` becomes its previous value minus one.
- R4: When `clear_n` is 1, `load` is 0 and `step_up` is 1 at a rising edge, `count` becomes its previous value plus three.
- R5: Stepping wraps modulo 16. 0 minus one gives 15, 14 plus three gives 1, 13 plus three gives 0, and 15 plus three gives 2.
- R6: With `clear_n` at 1 and `load` at 0, `count` differs from its previous value after every rising edge. There is no hold state.
- R7: Changes on the inputs between rising edges leave `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load | input | 1 | Synchronous parallel load, active high |
| din | input | 4 | Value copied into the counter on a load |
| step_up | input | 1 | 1 means step up by three, 0 means step down by one |
| count | output | 4 | Current counter value |

## Verification
The counter state is its output, so a wrong next value shows on `count` one edge after the control pattern that caused it. The bench therefore compares `count` after every edge. The state is not visible anywhere else, so a bad value is also carried into every later step. A chain of steps without a reload makes an arithmetic slip in the up or down path show at once. It also keeps the slip visible as a persistent offset, which matters most across the wrap points near 0 and 15. Priority mistakes between clear, load and direction show on the first edge where two controls are active together, so the vectors drive conflicting controls on purpose.

// File: rtl/clr_ld_counter.sv
module clr_ld_counter #(
  parameter int W       = 4,
  parameter int UP_STEP = 3,
  parameter int DN_STEP = 1
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         step_up,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] INC  = W'(UP_STEP);
  localparam logic [W-1:0] DEC  = W'(DN_STEP);

  logic [W-1:0] stepped;
  logic [W-1:0] nxt;

  assign stepped = step_up ? count + INC : count - DEC;

  always_comb begin
    if (!clear_n)  nxt = ZERO;
    else if (load) nxt = din;
    else           nxt = stepped;
  end

  always_ff @(posedge clk) count <= nxt;

endmodule

// File: rtl/clr_ld_counter_chk.sv
module clr_ld_counter_chk #(
  parameter int W       = 4,
  parameter int UP_STEP = 3,
  parameter int DN_STEP = 1
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load,
  input logic [W-1:0] din,
  input logic         step_up,
  input logic [W-1:0] count
);

  logic [1:0] armed = 2'b00;
  always_ff @(posedge clk) armed <= {armed[0], 1'b1};

  assert_clear_R1: assert property (@(posedge clk) disable iff (!armed[1])
    !clear_n |=> count == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!armed[1])
    (clear_n && load) |=> count == $past(din));

  assert_down_R3: assert property (@(posedge clk) disable iff (!armed[1])
    (clear_n && !load && !step_up) |=> count == W'($past(count) - W'(DN_STEP)));

  assert_up_R4: assert property (@(posedge clk) disable iff (!armed[1])
    (clear_n && !load && step_up) |=> count == W'($past(count) + W'(UP_STEP)));

  assert_no_hold_R6: assert property (@(posedge clk) disable iff (!armed[1])
    (clear_n && !load) |=> count != $past(count));

endmodule

bind clr_ld_counter clr_ld_counter_chk #(.W(W), .UP_STEP(UP_STEP), .DN_STEP(DN_STEP)) u_chk (
  .clk(clk), .clear_n(clear_n), .load(load), .din(din), .step_up(step_up), .count(count)
);

// File: tb/test_clr_ld_counter.sv
module test_clr_ld_counter;
  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] din = 4'd0;
  logic       step_up = 1'b0;
  logic [3:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clr_ld_counter i_clr_ld_counter (
    .clk(clk), .clear_n(clear_n), .load(load), .din(din), .step_up(step_up), .count(count)
  );

  // {clear_n, load, step_up, din[3:0], expected[3:0]}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 4'd9,  4'd0 },  // R1 clear beats load
    {1'b1, 1'b1, 1'b0, 4'd9,  4'd9 },  // R2
    {1'b1, 1'b0, 1'b0, 4'd3,  4'd8 },  // R3
    {1'b1, 1'b0, 1'b1, 4'd3,  4'd11},  // R4
    {1'b1, 1'b0, 1'b1, 4'd3,  4'd14},  // R4
    {1'b1, 1'b0, 1'b1, 4'd3,  4'd1 },  // R5 14+3
    {1'b1, 1'b0, 1'b0, 4'd3,  4'd0 },  // R3
    {1'b1, 1'b0, 1'b0, 4'd3,  4'd15},  // R5 0-1
    {1'b1, 1'b0, 1'b1, 4'd3,  4'd2 },  // R5 15+3
    {1'b1, 1'b1, 1'b1, 4'd13, 4'd13},  // R2 load beats up
    {1'b1, 1'b0, 1'b1, 4'd3,  4'd0 },  // R5 13+3
    {1'b0, 1'b0, 1'b0, 4'd5,  4'd0 },  // R1
    {1'b1, 1'b1, 1'b0, 4'd15, 4'd15},  // R2
    {1'b0, 1'b1, 1'b0, 4'd7,  4'd0 }   // R1
  };

  function automatic string tag_of(logic c, logic l, logic u);
    if (!c) return "R1";
    if (l)  return "R2";
    return u ? "R4" : "R3";
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s count=%0d expected=%0d", tag, count, exp);
    end
  endtask

  task automatic drive(logic c, logic l, logic u, logic [3:0] d);
    @(negedge clk);
    clear_n = c; load = l; step_up = u; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [3:0] model;
    logic [3:0] prev;
    drive(1'b0, 1'b0, 1'b0, 4'd0);
    check("R1", 4'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check(tag_of(VEC[i][10], VEC[i][9], VEC[i][8]), VEC[i][3:0]);
    end

    drive(1'b1, 1'b1, 1'b0, 4'd6);
    check("R2", 4'd6);
    model = 4'd6;
    for (int i = 0; i < 24; i++) begin
      prev = count;
      model = model + 4'd3;
      drive(1'b1, 1'b0, 1'b1, 4'd0);
      check("R4", model);
      checks++;
      if (count === prev) begin
        errors++;
        $display("FAIL R6 count=%0d expected=not %0d", count, prev);
      end
    end
    for (int i = 0; i < 20; i++) begin
      prev = count;
      model = model - 4'd1;
      drive(1'b1, 1'b0, 1'b0, 4'd0);
      check("R3", model);
      checks++;
      if (count === prev) begin
        errors++;
        $display("FAIL R6 count=%0d expected=not %0d", count, prev);
      end
    end

    // R7: wiggle inputs between edges, count must stay put until the edge
    drive(1'b1, 1'b1, 1'b0, 4'd10);
    check("R2", 4'd10);
    @(negedge clk);
    clear_n = 1'b0; load = 1'b1; din = 4'd3; step_up = 1'b1;
    #3;
    check("R7", 4'd10);
    clear_n = 1'b1; load = 1'b1; din = 4'd12;
    #3;
    check("R7", 4'd10);
    load = 1'b0; step_up = 1'b1;
    @(posedge clk);
    #1;
    check("R4", 4'd13);

    // R5 corner: clear then down wraps to 15
    drive(1'b0, 1'b0, 1'b1, 4'd0);
    check("R1", 4'd0);
    drive(1'b1, 1'b0, 1'b0, 4'd0);
    check("R5", 4'd15);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog count=%0d expected=finish", count);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule